// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block paces the SCL line of an I2C bus master. It counts instruction-cycle clocks against a programmable reload value. It toggles its SCL level output once every `reload + 1` cycles, so the bus clock runs at `Fcy / (2 * (reload + 1))`. With a 16 MHz counting clock, a reload of 79 gives 100 kHz, 19 gives 400 kHz and 7 gives 1 MHz. With a 2 MHz clock, the smallest legal reload of 2 gives about 333 kHz.

Each SCL transition comes with a single-cycle tick. A separate bus controller uses that tick to sequence START, STOP and data bits. The block samples the real bus level. While it has released SCL high but another device still holds the line low, the high-phase count is frozen, which honours clock stretching. Reload values below 2 are refused: the block stays idle and raises an error flag.

Top module: `scl_rate_gen`

## Requirements
- R1: While running, every SCL half period (high or low) lasts exactly `reload + 1` clock cycles, so consecutive `tick_o` pulses are `reload + 1` cycles apart.
- R2: When `en_i` is 1 and `reload_i` is below 2, `reload_err_o` is 1, `scl_o` stays 1 and no `tick_o` is produced. When `en_i` is 0, `reload_err_o` is 0.
- R3: `tick_o` is a one-cycle pulse that coincides with each change of `scl_o`. The first phase after enabling is high (`scl_o` = 1), so the first tick drives `scl_o` to 0.
- R4: While `en_i` is 0, `scl_o` is 1 and `tick_o` is 0, and the phase counter is cleared. After `en_i` rises with a valid reload, the first tick appears on the `reload + 2`-th falling clock edge after `en_i` was set.
- R5: While `scl_o` is 1 but `scl_sense_i` reads 0, the high-phase count is held. The phase then ends `reload + 1` cycles after the count resumes, counted from the last stretched cycle.
- R6: A new `reload_i` value takes effect only when the counter reloads at an SCL edge. A phase already in progress keeps its length.
- R7: After reset, `scl_o` is 1, `tick_o` is 0 and `reload_err_o` follows R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Instruction-cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| reload_i | input | RELOAD_W | Half-period reload value |
| scl_sense_i | input | 1 | Sampled SCL bus level |
| scl_o | output | 1 | SCL drive level, 1 = released |
| tick_o | output | 1 | One-cycle pulse at each SCL transition |
| reload_err_o | output | 1 | Enabled with a reload below the minimum |

## Verification
The assertions assume that `scl_sense_i` can only read low while the block itself drives SCL low or another device stretches the clock. They also assume that `reload_i` is a plain level sampled on the clock. The bench models the bus as a wired-AND of `scl_o` with a force-low control. It changes `en_i`, `reload_i` and the force-low control only on falling clock edges. Stretching is applied only in the high phase, which matches the one case where the counter is defined to freeze.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  localparam int unsigned MIN_RELOAD = 2;

  typedef enum logic {
    SCL_LOW  = 1'b0,
    SCL_HIGH = 1'b1
  } scl_lvl_e;
endpackage

// File: rtl/scl_reload_check.sv
module scl_reload_check #(
  parameter int unsigned RELOAD_W   = 9,
  parameter int unsigned MIN_RELOAD = scl_gen_pkg::MIN_RELOAD
) (
  input  logic                en_i,
  input  logic [RELOAD_W-1:0] reload_i,
  output logic                run_o,
  output logic                err_o
);
  localparam logic [RELOAD_W-1:0] MinVal = RELOAD_W'(MIN_RELOAD);

  logic too_small;
  assign too_small = (reload_i < MinVal);
  assign err_o     = en_i & too_small;
  assign run_o     = en_i & ~too_small;

  always_comb begin
    a_r2_err_excl : assert (!(err_o && run_o));
  end
endmodule

// File: rtl/scl_half_counter.sv
module scl_half_counter #(
  parameter int unsigned RELOAD_W = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                hold_i,
  input  logic [RELOAD_W-1:0] reload_i,
  output logic                done_o
);
  logic [RELOAD_W-1:0] cnt_q;
  logic                active_q;

  assign done_o = run_i & active_q & ~hold_i & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (!active_q) begin
      cnt_q    <= reload_i;   // first phase after start
      active_q <= 1'b1;
    end else if (hold_i) begin
      cnt_q    <= cnt_q;      // clock stretch
    end else if (cnt_q == '0) begin
      cnt_q    <= reload_i;   // new value only at an edge
    end else begin
      cnt_q    <= cnt_q - 1'b1;
    end
  end

  a_r5_stretch_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && active_q && hold_i) |=> (cnt_q == $past(cnt_q)));

  a_r4_cnt_clear : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0 && !active_q));

  a_r6_mid_phase : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && active_q && !hold_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic done_i,
  output logic scl_o,
  output logic tick_o
);
  import scl_gen_pkg::*;

  scl_lvl_e lvl_q;
  logic     tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= SCL_HIGH;
      tick_q <= 1'b0;
    end else if (!run_i) begin
      lvl_q  <= SCL_HIGH;
      tick_q <= 1'b0;
    end else begin
      tick_q <= done_i;
      if (done_i) lvl_q <= (lvl_q == SCL_HIGH) ? SCL_LOW : SCL_HIGH;
    end
  end

  assign scl_o  = (lvl_q == SCL_HIGH);
  assign tick_o = tick_q;

  a_r3_tick_toggle : assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (scl_o != $past(scl_o)));

  a_r3_quiet_level : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !done_i) |=> (!tick_o && $stable(scl_o)));

  a_r4_release : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (scl_o && !tick_o));
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int unsigned RELOAD_W   = 9,
  parameter int unsigned MIN_RELOAD = scl_gen_pkg::MIN_RELOAD
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                scl_sense_i,
  output logic                scl_o,
  output logic                tick_o,
  output logic                reload_err_o
);
  logic run, done, hold;

  scl_reload_check #(
    .RELOAD_W  (RELOAD_W),
    .MIN_RELOAD(MIN_RELOAD)
  ) u_check (
    .en_i    (en_i),
    .reload_i(reload_i),
    .run_o   (run),
    .err_o   (reload_err_o)
  );

  // released high but bus still low: another device stretches SCL
  assign hold = scl_o & ~scl_sense_i;

  scl_half_counter #(
    .RELOAD_W(RELOAD_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .hold_i  (hold),
    .reload_i(reload_i),
    .done_o  (done)
  );

  scl_phase_ctrl u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .done_i(done),
    .scl_o (scl_o),
    .tick_o(tick_o)
  );

  a_r2_err_idle : assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_err_o |=> (scl_o && !tick_o));

  a_r5_no_tick_stretched : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o && !scl_sense_i) |=> !(tick_o && !scl_o && $past(scl_o)));
endmodule

// File: tb/scl_rate_gen_test.sv
module scl_rate_gen_test;
  localparam int W = 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] reload = '0;
  logic         force_low = 1'b0;
  logic         scl, tick, err;
  logic         sense;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  assign sense = scl & ~force_low;

  scl_rate_gen #(.RELOAD_W(W)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .reload_i    (reload),
    .scl_sense_i (sense),
    .scl_o       (scl),
    .tick_o      (tick),
    .reload_err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 2000);
  endtask

  task automatic start(input int r);
    @(negedge clk);
    en = 1'b1;
    reload = W'(r);
  endtask

  task automatic stop();
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R7 scl after reset", int'(scl), 1);
    chk("R7 tick after reset", int'(tick), 0);
    chk("R7 err after reset", int'(err), 0);
  endtask

  task automatic t_rate(input int r);
    int n;
    start(r);
    gap(n);
    chk("R4 first tick delay", n, r + 2);
    chk("R3 first phase was high", int'(scl), 0);
    @(negedge clk);
    chk("R3 tick one cycle", int'(tick), 0);
    gap(n);
    chk("R1 half period", n, r);
    for (int i = 0; i < 3; i++) begin
      gap(n);
      chk("R1 half period", n, r + 1);
    end
    stop();
  endtask

  task automatic t_invalid();
    int ticks = 0;
    int lowseen = 0;
    @(negedge clk);
    en = 1'b0;
    reload = W'(0);
    #1;
    chk("R2 err low when disabled", int'(err), 0);
    for (int v = 0; v < 2; v++) begin
      @(negedge clk);
      en = 1'b1;
      reload = W'(v);
      #1;
      chk("R2 err raised", int'(err), 1);
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (tick) ticks++;
        if (!scl) lowseen++;
      end
    end
    chk("R2 no ticks on bad reload", ticks, 0);
    chk("R2 scl released on bad reload", lowseen, 0);
    stop();
  endtask

  task automatic t_disable();
    int n;
    int ticks = 0;
    int lowseen = 0;
    start(7);
    gap(n);
    gap(n);
    repeat (3) @(negedge clk);
    en = 1'b0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (tick) ticks++;
      if (!scl) lowseen++;
    end
    chk("R4 no tick disabled", ticks, 0);
    chk("R4 scl released disabled", lowseen, 0);
    start(7);
    gap(n);
    chk("R4 fresh phase after re-enable", n, 9);
    stop();
  endtask

  task automatic t_stretch();
    int n;
    int bad = 0;
    start(5);
    gap(n);
    gap(n);
    chk("R3 back to high", int'(scl), 1);
    force_low = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (tick || !scl) bad++;
    end
    force_low = 1'b0;
    chk("R5 held while stretched", bad, 0);
    gap(n);
    chk("R5 resumes after release", n, 6);
    gap(n);
    chk("R5 low phase unaffected", n, 6);
    stop();
  endtask

  task automatic t_change();
    int n;
    start(9);
    gap(n);
    repeat (3) @(negedge clk);
    reload = W'(4);
    gap(n);
    chk("R6 current phase keeps length", n, 7);
    gap(n);
    chk("R6 new value next phase", n, 5);
    stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rate(7);
    t_rate(2);
    t_rate(19);
    t_rate(79);
    t_invalid();
    t_disable();
    t_stretch();
    t_change();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule